// File: doc/BRIEF.md
# Local Bus Burst Master

This block moves a block of 32-bit words across a shared local bus as one or more burst cycles. A request gives a start address, a word count, a burst length code and a direction. The block then asks for the bus, waits for the grant, and issues an address strobe. It counts data phases, each of which a slave completes with a ready strobe. The final phase of every burst carries a last-phase strobe, and no burst runs past an aligned block whose size is the selected burst length.

A slave may end a burst early. It does this by asserting the terminate strobe in the same cycle as ready. The block treats that phase as the final one and strobes a fresh address in the next cycle, at the first word not yet moved. Write data comes from the user side through a word index, and read data goes back with its index one cycle after each completed phase. When the last word is done, the block releases the bus request, pulses `done` and returns to idle.

Top module: `burst_master`

## Requirements
- R1: During and right after reset, `hold` and `done` are low, and `ads_n`, `blast_n` and `wr_n` are high.
- R2: A `start` with a nonzero `word_count` raises `hold` in the next cycle. `ads_n` is driven low only while `hold` and `hlda` are both high.
- R3: Each burst opens with exactly one cycle of `ads_n` low. During that cycle `addr` holds the first word not yet transferred, and the first burst of a request starts at `start_addr` with bits [1:0] forced to zero.
- R4: A data phase completes on a clock edge where `ready_n` is low. Each completed phase moves one word, and `addr` rises by 4 after it, so every word of the request goes across exactly once and in ascending order.
- R5: `burst_len_sel` values 0, 1, 2 and 3 select bursts of 4, 16, 64 and 256 words. No burst holds two words that lie in different aligned blocks of that size.
- R6: `blast_n` is low in a data phase exactly when that phase is the last one of its burst. A burst ends when the request runs out of words or when the next word would start a new aligned block.
- R7: While a data phase waits with `ready_n` high, `addr`, `blast_n` and the write data stay stable, and a low `bterm_n` in that cycle is ignored.
- R8: If `bterm_n` and `ready_n` are both low in a data phase and words remain, that phase ends the burst. `ads_n` goes low in the very next cycle at the next word's address.
- R9: A write request holds `wr_n` low through the address and data phases and drives `bus_dout` from `wdata` for the word numbered `word_idx`, counting from 0. A read request holds `wr_n` high. One cycle after each completed read phase, `rdata_valid` pulses with the sampled `bus_din` on `rdata` and its word number on `rdata_idx`.
- R10: In the cycle after the last word completes, `hold` is low and `done` is high for one cycle. A `start` with a `word_count` of zero, or a `start` that arrives while a request is running, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request strobe, sampled while idle |
| start_addr | input | ADDR_W | Byte address of the first word |
| word_count | input | CNT_W | Number of words to move |
| burst_len_sel | input | SEL_W | Burst length code (4 << 2*code words) |
| write | input | 1 | 1 = write to the bus, 0 = read |
| hold | output | 1 | Bus request |
| hlda | input | 1 | Bus grant |
| ads_n | output | 1 | Address strobe, active low |
| addr | output | ADDR_W | Bus byte address |
| blast_n | output | 1 | Last phase of burst, active low |
| ready_n | input | 1 | Data phase completion, active low |
| bterm_n | input | 1 | Slave burst termination, active low |
| wr_n | output | 1 | Write cycle indicator, active low |
| bus_din | input | DATA_W | Read data from the bus |
| bus_dout | output | DATA_W | Write data to the bus |
| wdata | input | DATA_W | User write data for word `word_idx` |
| word_idx | output | CNT_W | Number of the current word within the request |
| rdata | output | DATA_W | Read word to the user |
| rdata_valid | output | 1 | `rdata` is valid |
| rdata_idx | output | CNT_W | Word number of `rdata` |
| done | output | 1 | One-cycle pulse when the request is finished |

## Verification
A slave model answers with random wait states and random terminate strobes. Some of those strobes fall without ready and must therefore have no effect. Expected addresses, burst lengths and last-phase positions are computed from a running word counter. Directed requests start just below a 16-byte boundary and just below a 1 KB boundary, which separates correct boundary splitting from off-by-one splits. A request with terminate on every phase gives only single-word bursts, which tests the restart path. Single-word, zero-count and mid-transfer restart requests test the edges of the request handshake. Reads and writes are mixed so that index tracking in both directions is covered.

// File: rtl/bm_pkg.sv
package bm_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_REQ,
      ST_ADS,
      ST_DATA,
      ST_FIN
   } bm_state_e;
endpackage

// File: rtl/bm_len_table.sv
// Maps a burst length code to (burst words - 1), used as an alignment mask.
module bm_len_table #(
   parameter int SEL_W    = 2,
   parameter int MIN_LOG  = 2,
   parameter int STEP_LOG = 2,
   parameter int LEN_W    = 9
) (
   input  logic [SEL_W-1:0] sel,
   output logic [LEN_W-1:0] mask
);
   localparam int NUM_SEL = 1 << SEL_W;

   logic [LEN_W-1:0] tbl [NUM_SEL];

   for (genvar g = 0; g < NUM_SEL; g++) begin : len_g
      assign tbl[g] = LEN_W'((1 << (MIN_LOG + g * STEP_LOG)) - 1);
   end

   assign mask = tbl[sel];
endmodule

// File: rtl/bm_addr_gen.sv
// Word address, remaining count and per-burst phase counter.
module bm_addr_gen #(
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 16,
   parameter int LEN_W  = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_addr,
   input  logic [CNT_W-1:0]  load_cnt,
   input  logic              open,
   input  logic              advance,
   input  logic [LEN_W-1:0]  len_mask,
   output logic [ADDR_W-1:0] addr,
   output logic [CNT_W-1:0]  word_idx,
   output logic              last_word,
   output logic              last_in_burst,
   output logic              at_block_end
);
   logic [ADDR_W-1:0] addr_q;
   logic [CNT_W-1:0]  left_q;
   logic [CNT_W-1:0]  idx_q;
   logic [LEN_W-1:0]  burst_q;
   logic [LEN_W-1:0]  offset;
   logic [LEN_W-1:0]  to_bound;
   logic [LEN_W-1:0]  burst_words;

   // position of the current word inside its aligned block
   assign offset      = addr_q[2 +: LEN_W] & len_mask;
   assign to_bound    = len_mask - offset + LEN_W'(1);
   assign burst_words = (left_q < CNT_W'(to_bound)) ? left_q[LEN_W-1:0] : to_bound;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         left_q  <= '0;
         idx_q   <= '0;
         burst_q <= '0;
      end else begin
         if (load) begin
            addr_q <= {load_addr[ADDR_W-1:2], 2'b00};
            left_q <= load_cnt;
            idx_q  <= '0;
         end else if (advance) begin
            addr_q <= addr_q + ADDR_W'(4);
            left_q <= left_q - CNT_W'(1);
            idx_q  <= idx_q + CNT_W'(1);
         end
         if (open) begin
            burst_q <= burst_words;
         end else if (advance) begin
            burst_q <= burst_q - LEN_W'(1);
         end
      end
   end

   assign addr          = addr_q;
   assign word_idx      = idx_q;
   assign last_word     = (left_q == CNT_W'(1));
   assign last_in_burst = (burst_q == LEN_W'(1));
   assign at_block_end  = (offset == len_mask);

   // R5
   burst_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      open |-> (burst_words != '0))
      else $error("burst opened with no words");
endmodule

// File: rtl/bm_fsm.sv
// Bus ownership and phase sequencing.
module bm_fsm
   import bm_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic cnt_nz,
   input  logic hlda,
   input  logic ready_n,
   input  logic bterm_n,
   input  logic last_word,
   input  logic last_in_burst,
   output logic hold,
   output logic ads_n,
   output logic data_phase,
   output logic load,
   output logic open,
   output logic advance,
   output logic done
);
   bm_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_IDLE: if (start && cnt_nz) state_d = ST_REQ;
         ST_REQ:  if (hlda) state_d = ST_ADS;
         ST_ADS:  state_d = ST_DATA;
         ST_DATA: begin
            if (!ready_n) begin
               if (last_word) begin
                  state_d = ST_FIN;
               end else if (last_in_burst || !bterm_n) begin
                  state_d = ST_ADS;
               end
            end
         end
         ST_FIN:  state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   assign hold       = (state_q == ST_REQ) || (state_q == ST_ADS) || (state_q == ST_DATA);
   assign ads_n      = (state_q != ST_ADS);
   assign data_phase = (state_q == ST_DATA);
   assign load       = (state_q == ST_IDLE) && start && cnt_nz;
   assign open       = (state_q == ST_ADS);
   assign advance    = data_phase && !ready_n;
   assign done       = (state_q == ST_FIN);

   // R2
   ads_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ads_n |-> (hlda && hold))
      else $error("address strobe without grant");

   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && !hold))
      else $error("done longer than one cycle");
endmodule

// File: rtl/bm_rd_path.sv
// Read return path; RD_REG selects a registered or a direct variant.
module bm_rd_path #(
   parameter int DATA_W = 32,
   parameter int CNT_W  = 16,
   parameter bit RD_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture,
   input  logic [DATA_W-1:0] din,
   input  logic [CNT_W-1:0]  idx,
   output logic [DATA_W-1:0] rdata,
   output logic              valid,
   output logic [CNT_W-1:0]  ridx
);
   if (RD_REG) begin : reg_g
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rdata <= '0;
            valid <= 1'b0;
            ridx  <= '0;
         end else begin
            valid <= capture;
            if (capture) begin
               rdata <= din;
               ridx  <= idx;
            end
         end
      end
   end else begin : comb_g
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign rdata = din;
      assign valid = capture;
      assign ridx  = idx;
   end
endmodule

// File: rtl/burst_master.sv
module burst_master #(
   parameter int ADDR_W   = 32,
   parameter int DATA_W   = 32,
   parameter int CNT_W    = 16,
   parameter int SEL_W    = 2,
   parameter int MIN_LOG  = 2,
   parameter int STEP_LOG = 2,
   parameter bit RD_REG   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic [CNT_W-1:0]  word_count,
   input  logic [SEL_W-1:0]  burst_len_sel,
   input  logic              write,
   output logic              hold,
   input  logic              hlda,
   output logic              ads_n,
   output logic [ADDR_W-1:0] addr,
   output logic              blast_n,
   input  logic              ready_n,
   input  logic              bterm_n,
   output logic              wr_n,
   input  logic [DATA_W-1:0] bus_din,
   output logic [DATA_W-1:0] bus_dout,
   input  logic [DATA_W-1:0] wdata,
   output logic [CNT_W-1:0]  word_idx,
   output logic [DATA_W-1:0] rdata,
   output logic              rdata_valid,
   output logic [CNT_W-1:0]  rdata_idx,
   output logic              done
);
   localparam int NUM_SEL = 1 << SEL_W;
   localparam int MAX_LOG = MIN_LOG + (NUM_SEL - 1) * STEP_LOG;
   localparam int LEN_W   = MAX_LOG + 1;

   if (ADDR_W < LEN_W + 2) begin : bad_addr_g
      $error("burst_master: ADDR_W too narrow for the largest burst");
   end
   if (CNT_W < LEN_W) begin : bad_cnt_g
      $error("burst_master: CNT_W narrower than a burst length");
   end
   if (DATA_W != 32) begin : bad_data_g
      $error("burst_master: only full 32-bit words are supported");
   end

   logic              unused_lsb;
   logic [SEL_W-1:0]  sel_q;
   logic              write_q;
   logic [LEN_W-1:0]  len_mask;
   logic              load, open, advance, data_phase;
   logic              last_word, last_in_burst, at_block_end;

   assign unused_lsb = ^start_addr[1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q   <= '0;
         write_q <= 1'b0;
      end else if (load) begin
         sel_q   <= burst_len_sel;
         write_q <= write;
      end
   end

   bm_len_table #(
      .SEL_W   (SEL_W),
      .MIN_LOG (MIN_LOG),
      .STEP_LOG(STEP_LOG),
      .LEN_W   (LEN_W)
   ) u_len (
      .sel (sel_q),
      .mask(len_mask)
   );

   bm_addr_gen #(
      .ADDR_W(ADDR_W),
      .CNT_W (CNT_W),
      .LEN_W (LEN_W)
   ) u_agen (
      .clk          (clk),
      .rst_n        (rst_n),
      .load         (load),
      .load_addr    (start_addr),
      .load_cnt     (word_count),
      .open         (open),
      .advance      (advance),
      .len_mask     (len_mask),
      .addr         (addr),
      .word_idx     (word_idx),
      .last_word    (last_word),
      .last_in_burst(last_in_burst),
      .at_block_end (at_block_end)
   );

   bm_fsm u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .start        (start),
      .cnt_nz       (word_count != '0),
      .hlda         (hlda),
      .ready_n      (ready_n),
      .bterm_n      (bterm_n),
      .last_word    (last_word),
      .last_in_burst(last_in_burst),
      .hold         (hold),
      .ads_n        (ads_n),
      .data_phase   (data_phase),
      .load         (load),
      .open         (open),
      .advance      (advance),
      .done         (done)
   );

   bm_rd_path #(
      .DATA_W(DATA_W),
      .CNT_W (CNT_W),
      .RD_REG(RD_REG)
   ) u_rd (
      .clk    (clk),
      .rst_n  (rst_n),
      .capture(advance && !write_q),
      .din    (bus_din),
      .idx    (word_idx),
      .rdata  (rdata),
      .valid  (rdata_valid),
      .ridx   (rdata_idx)
   );

   assign blast_n  = !(data_phase && last_in_burst);
   assign wr_n     = !(write_q && (!ads_n || data_phase));
   assign bus_dout = wdata;

   // R5
   no_cross_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (data_phase && at_block_end) |-> !blast_n)
      else $error("burst continues past aligned block");

   // R7
   wait_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (data_phase && ready_n) |=> ($stable(addr) && $stable(blast_n)))
      else $error("address or last strobe moved during wait");

   // R8
   bterm_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (data_phase && !ready_n && !bterm_n && !last_word) |=> !ads_n)
      else $error("no restart after slave termination");

   // R3
   ads_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ads_n |=> ads_n)
      else $error("address strobe longer than one cycle");
endmodule

// File: tb/sim_burst_master.sv
module sim_burst_master;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] start_addr = '0;
   logic [15:0] word_count = '0;
   logic [1:0]  burst_len_sel = '0;
   logic        write = 1'b0;
   logic        hold, ads_n, blast_n, wr_n, rdata_valid, done;
   logic        hlda = 1'b0;
   logic        ready_n = 1'b1;
   logic        bterm_n = 1'b1;
   logic [31:0] addr, bus_dout, rdata, wdata;
   logic [31:0] bus_din = '0;
   logic [15:0] word_idx, rdata_idx;

   int n_chk = 0;
   int n_fail = 0;

   // bench model state
   logic [31:0] exp_addr, burst_base, rd_base;
   int          exp_left = 0, exp_idx = 0, lw = 4;
   int          wait_pct = 0, bterm_pct = 0, hlda_wait = 0;
   int          burst_len_e = 0, burst_cnt = 0, rd_exp_idx = 0;
   bit          in_burst = 0, need_ads = 0, fin_expect = 0, wr_mode = 0;
   bit          rdy, bt;
   logic [15:0] wtag = 16'h0;
   int          seed_init;

   always #2 clk = ~clk;

   burst_master u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
      .word_count(word_count), .burst_len_sel(burst_len_sel), .write(write),
      .hold(hold), .hlda(hlda), .ads_n(ads_n), .addr(addr), .blast_n(blast_n),
      .ready_n(ready_n), .bterm_n(bterm_n), .wr_n(wr_n), .bus_din(bus_din),
      .bus_dout(bus_dout), .wdata(wdata), .word_idx(word_idx), .rdata(rdata),
      .rdata_valid(rdata_valid), .rdata_idx(rdata_idx), .done(done)
   );

   function automatic logic [31:0] rpat(input logic [31:0] a);
      return {a[15:0] ^ 16'h5A3C, ~a[15:0]};
   endfunction

   function automatic logic [31:0] wpat(input logic [15:0] i);
      return {wtag, i ^ 16'h0F0F};
   endfunction

   function automatic int exp_burst(input logic [31:0] a, input int left, input int l);
      int off = int'(a >> 2) % l;
      int to_b = l - off;
      return (left < to_b) ? left : to_b;
   endfunction

   assign wdata = wpat(word_idx);

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // slave model: observes the current cycle, then drives the next edge
   always @(negedge clk) begin
      if (!rst_n) begin
         hlda = 1'b0; ready_n = 1'b1; bterm_n = 1'b1;
      end else begin
         ready_n = 1'b1;
         bterm_n = 1'b1;
         if (fin_expect) begin
            chk(done && !hold, "R10 done pulse and hold released", {30'd0, done, hold}, 32'h2);
            fin_expect = 0;
         end
         if (in_burst) begin
            chk(blast_n == !(burst_cnt == burst_len_e - 1), "R6 last-phase strobe",
                {31'd0, blast_n}, {31'd0, !(burst_cnt == burst_len_e - 1)});
            rdy = ($urandom % 100) >= wait_pct;
            bt  = ($urandom % 100) < bterm_pct;
            if (rdy) begin
               chk(addr == exp_addr, "R4 word address in order", addr, exp_addr);
               chk(int'(addr >> 2) / lw == int'(burst_base >> 2) / lw,
                   "R5 burst stays in aligned block", addr, burst_base);
               if (wr_mode) begin
                  chk(!wr_n && bus_dout == wpat(exp_idx[15:0]), "R9 write data and wr_n",
                      bus_dout, wpat(exp_idx[15:0]));
               end else begin
                  chk(wr_n, "R9 wr_n high on read", {31'd0, wr_n}, 32'd1);
                  bus_din = rpat(addr);
               end
               exp_addr = exp_addr + 32'd4;
               exp_left--;
               exp_idx++;
               burst_cnt++;
               if (!blast_n || bt) begin
                  in_burst = 0;
                  if (exp_left > 0) need_ads = 1;
               end
               if (exp_left == 0) fin_expect = 1;
            end
            ready_n = !rdy;
            bterm_n = !bt;
         end else if (!ads_n) begin
            chk(addr == exp_addr, "R3 burst start address", addr, exp_addr);
            chk(hlda && hold, "R2 strobe only with grant", {30'd0, hlda, hold}, 32'h3);
            burst_len_e = exp_burst(exp_addr, exp_left, lw);
            burst_cnt = 0;
            burst_base = exp_addr;
            in_burst = 1;
            need_ads = 0;
         end else if (need_ads) begin
            chk(1'b0, "R8 restart strobe in next cycle", {31'd0, ads_n}, 32'd0);
            need_ads = 0;
         end
         if (hold) begin
            if (hlda_wait > 0) hlda_wait--;
            else hlda = 1'b1;
         end else begin
            hlda = 1'b0;
            hlda_wait = $urandom_range(0, 3);
         end
      end
   end

   // read return checker
   always @(negedge clk) begin
      if (rst_n && rdata_valid) begin
         chk(rdata_idx == rd_exp_idx[15:0], "R9 read index", {16'd0, rdata_idx}, rd_exp_idx);
         chk(rdata == rpat(rd_base + 32'(rd_exp_idx) * 4), "R9 read data", rdata,
             rpat(rd_base + 32'(rd_exp_idx) * 4));
         rd_exp_idx++;
      end
   end

   task automatic run_xfer(input logic [31:0] a, input int cnt, input int sel, input bit w,
                           input int wp, input int bp, input bit poke);
      int n = 0;
      @(negedge clk);
      exp_addr = a; exp_left = cnt; exp_idx = 0; lw = 4 << (2 * sel);
      wait_pct = wp; bterm_pct = bp; wr_mode = w; rd_base = a; rd_exp_idx = 0;
      wtag = 16'($urandom);
      start = 1'b1; start_addr = a; word_count = 16'(cnt);
      burst_len_sel = 2'(sel); write = w;
      @(negedge clk);
      start = 1'b0;
      if (cnt == 0) begin
         repeat (6) begin
            @(negedge clk);
            chk(!hold && ads_n && !done, "R10 zero count ignored", {30'd0, hold, done}, 32'd0);
         end
      end else begin
         chk(hold, "R2 hold after start", {31'd0, hold}, 32'd1);
         while (!done) begin
            @(negedge clk);
            n++;
            if (poke && n == 5) begin
               start = 1'b1; start_addr = a + 32'h100; word_count = 16'd3;
            end else begin
               start = 1'b0;
            end
         end
         start = 1'b0;
         @(negedge clk);
         #1;
         chk(exp_idx == cnt, "R4 every word exactly once", exp_idx, cnt);
         if (!w) chk(rd_exp_idx == cnt, "R9 read word count", rd_exp_idx, cnt);
         chk(!hold && !done, "R10 back to idle", {30'd0, hold, done}, 32'd0);
      end
   endtask

   initial begin
      seed_init = $urandom(32'd20211);
      repeat (3) @(negedge clk);
      chk(!hold && ads_n && blast_n && wr_n && !done, "R1 reset outputs",
          {27'd0, hold, ads_n, blast_n, wr_n, done}, 32'h0E);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!hold && ads_n && blast_n && wr_n && !done, "R1 idle after reset",
          {27'd0, hold, ads_n, blast_n, wr_n, done}, 32'h0E);
      // directed corners
      run_xfer(32'h0000_000C, 6, 0, 1'b1, 0, 0, 1'b0);   // R5 16-byte split
      run_xfer(32'h0000_03F8, 5, 3, 1'b0, 0, 0, 1'b0);   // R5 1 KB split
      run_xfer(32'h0000_0040, 9, 1, 1'b0, 0, 100, 1'b0); // R8 terminate every phase
      run_xfer(32'h0000_0104, 1, 2, 1'b1, 30, 0, 1'b0);  // R6 single word
      run_xfer(32'h0000_0200, 0, 0, 1'b0, 0, 0, 1'b0);   // R10 zero count
      run_xfer(32'h0000_0020, 12, 0, 1'b1, 20, 10, 1'b1);// R10 start while busy
      run_xfer(32'h0000_0080, 20, 1, 1'b0, 80, 50, 1'b0);// R7 long waits
      for (int k = 0; k < 24; k++) begin
         run_xfer(32'($urandom_range(0, 1023)) << 2, int'($urandom_range(1, 40)),
                  int'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
                  int'($urandom_range(0, 60)), int'($urandom_range(0, 30)), 1'b0);
      end
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL R10 watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule